// File: doc/BRIEF.md
# Square-Wave Voice with Duty Sequencer

This block produces one square-wave voice for a sound generator. Software programs it through a small register interface: a control register sets a 2-bit duty selector, and two further registers together hold an 11-bit period. A divide-by-two toggle creates a half-rate tick. On every tick a down-counting timer advances. Each time the timer wraps from zero back to the programmed period, an 8-position waveform sequencer steps once. The current pattern bit then gates a 4-bit level that comes in from outside.

Volume, a sweep-overflow mute and a length-counter-exhausted flag are all inputs; the logic behind them lives elsewhere. The voice drives its level to zero whenever the pattern bit is low, when either mute input is high, or when the programmed period is too short to be audible.

A write to the period-high register sends the sequencer back to its starting position and raises a one-clock restart pulse for an external envelope unit. That write does not disturb the running timer count. The output level is registered, so it reflects the state and inputs present at the previous clock edge.

Top module: `sq_voice_top`

## Requirements
- R1: After synchronous reset, `level_out` is 0 and `env_restart` is 0.
- R2: A write to index 2 loads period bits 7:0 from `wr_data`. A write to index 3 loads period bits 10:8 from `wr_data[2:0]`. The timer moves once every two clocks and steps the sequencer once per t+1 moves, so one waveform lasts 16*(t+1) clocks.
- R3: The position starts at 0 and steps downward modulo 8 (0,7,6,...,1). The high positions for each duty code are: code 0, position 1 only; code 1, positions 1–2; code 2, positions 1–4; code 3, every position except 1 and 2. Over one waveform the output is nonzero for 2, 4, 8 and 12 times (t+1) clocks respectively.
- R4: A write to index 0 takes its duty code from `wr_data[7:6]`. The new pattern shows on the output on the clock after the write, and the sequence position is left as it was.
- R5: A write to index 3 puts the sequence position at 0, so with duty 3 the output shows the volume on the next clock.
- R6: `env_restart` is high for exactly the one clock after a write to index 3 and stays low after writes to any other index.
- R7: A write to index 3 leaves the timer count alone: the following steps keep the timing they had before the write.
- R8: A period below 8 forces the output to 0; a period of exactly 8 does not.
- R9: `sweep_mute` high forces the output to 0 on the next clock.
- R10: `len_zero` high forces the output to 0 on the next clock.
- R11: When nothing mutes it, the output equals `vol_in` as sampled at the previous clock edge.
- R12: Writes to index 1, `wr_data[5:0]` of an index-0 write and `wr_data[7:3]` of an index-3 write change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index (0 control, 1 unused, 2 period low, 3 period high) |
| wr_data | input | 8 | Register write data |
| vol_in | input | 4 | Volume level to pass through when unmuted |
| sweep_mute | input | 1 | Mute request from sweep overflow |
| len_zero | input | 1 | Length counter has reached zero |
| env_restart | output | 1 | One-clock envelope restart pulse |
| level_out | output | 4 | Registered output level |

## Verification
The hardest thing to show from the ports is that a period-high write leaves the timer count alone, because the count is never visible. The stimulus locks onto the timer phase by waiting for a falling output edge under duty 3; a sequencer step has just happened at that edge. It then issues the period-high write part-way through the step interval and times the next falling edge. That edge must come exactly six step intervals after the first one, and not six intervals after the write. The duty-switch test uses the same approach: it locks onto a rising edge and rewrites the duty code several times before the next step can arrive.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int PER_W   = 11;
  localparam int SEQ_LEN = 8;
  localparam int POS_W   = $clog2(SEQ_LEN);
  localparam int MIN_PER = 8;

  localparam logic [1:0] IDX_CTRL  = 2'd0;
  localparam logic [1:0] IDX_PLOW  = 2'd2;
  localparam logic [1:0] IDX_PHIGH = 2'd3;

  typedef logic [1:0] duty_t;

  // bit p of each mask is the pattern value at sequence position p
  function automatic logic pattern_bit(input duty_t duty, input logic [POS_W-1:0] pos);
    logic [SEQ_LEN-1:0] mask;
    case (duty)
      2'd0:    mask = 8'h02;
      2'd1:    mask = 8'h06;
      2'd2:    mask = 8'h1E;
      default: mask = 8'hF9;
    endcase
    return mask[pos];
  endfunction
endpackage

// File: rtl/sq_regfile.sv
module sq_regfile
  import sq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output duty_t             duty_d,
  output logic [PER_W-1:0]  period_d,
  output logic [PER_W-1:0]  period_q,
  output logic              hi_wr
);
  localparam int LO_W = 8;
  localparam int HI_W = PER_W - LO_W;

  duty_t duty_q;

  always_comb begin
    duty_d   = duty_q;
    period_d = period_q;
    hi_wr    = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        ADDR_W'(IDX_CTRL):  duty_d = wr_data[DATA_W-1 -: 2];
        ADDR_W'(IDX_PLOW):  period_d[LO_W-1:0] = wr_data[LO_W-1:0];
        ADDR_W'(IDX_PHIGH): begin
          period_d[PER_W-1:LO_W] = wr_data[HI_W-1:0];
          hi_wr = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q   <= '0;
      period_q <= '0;
    end else begin
      duty_q   <= duty_d;
      period_q <= period_d;
    end
  end
endmodule

// File: rtl/sq_timer.sv
module sq_timer
  import sq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period_q,
  output logic             step
);
  logic             tick_q;
  logic [PER_W-1:0] cnt_q;

  assign step = tick_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      tick_q <= ~tick_q;
      if (tick_q) begin
        if (cnt_q == '0) cnt_q <= period_q;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sq_seq.sv
module sq_seq
  import sq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             restart,
  output logic [POS_W-1:0] pos_d,
  output logic [POS_W-1:0] pos_q
);
  always_comb begin
    if (restart)   pos_d = '0;
    else if (step) pos_d = pos_q - 1'b1;
    else           pos_d = pos_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pos_q <= '0;
    else     pos_q <= pos_d;
  end
endmodule

// File: rtl/sq_voice_top.sv
module sq_voice_top
  import sq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int VOL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [VOL_W-1:0]  vol_in,
  input  logic              sweep_mute,
  input  logic              len_zero,
  output logic              env_restart,
  output logic [VOL_W-1:0]  level_out
);
  duty_t            duty_d;
  logic [PER_W-1:0] period_d, period_q;
  logic             hi_wr, seq_step;
  logic [POS_W-1:0] pos_d, pos_q;
  logic             audible;

  sq_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .duty_d(duty_d), .period_d(period_d), .period_q(period_q), .hi_wr(hi_wr)
  );

  sq_timer u_timer (
    .clk(clk), .rst(rst), .period_q(period_q), .step(seq_step)
  );

  sq_seq u_seq (
    .clk(clk), .rst(rst), .step(seq_step), .restart(hi_wr),
    .pos_d(pos_d), .pos_q(pos_q)
  );

  // gate on next-state values so the output moves on the same edge as the state
  assign audible = pattern_bit(duty_d, pos_d) && !sweep_mute && !len_zero &&
                   (period_d >= PER_W'(MIN_PER));

  always_ff @(posedge clk) begin
    if (rst) begin
      level_out   <= '0;
      env_restart <= 1'b0;
    end else begin
      level_out   <= audible ? vol_in : '0;
      env_restart <= hi_wr;
    end
  end
endmodule

// File: rtl/sq_voice_chk.sv
module sq_voice_chk
  import sq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int VOL_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [VOL_W-1:0]  vol_in,
  input logic              sweep_mute,
  input logic              len_zero,
  input logic              env_restart,
  input logic [VOL_W-1:0]  level_out,
  input logic [PER_W-1:0]  period_q,
  input logic [POS_W-1:0]  pos_q,
  input logic              seq_step
);
  logic hi_w, ctrl_w;
  assign hi_w   = wr_en && (wr_addr == ADDR_W'(IDX_PHIGH));
  assign ctrl_w = wr_en && (wr_addr == ADDR_W'(IDX_CTRL));

  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (rst) hi_w |=> env_restart); // R6
  AST_RESTART_ONLY_HI: assert property (@(posedge clk) disable iff (rst) !hi_w |=> !env_restart); // R6
  AST_RESTART_POS: assert property (@(posedge clk) disable iff (rst) hi_w |=> (pos_q == '0)); // R5
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (seq_step && !hi_w) |=> (pos_q == POS_W'($past(pos_q) - 1'b1))); // R3
  AST_DUTY_KEEPS_POS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_w && !seq_step) |=> $stable(pos_q)); // R4
  AST_SHORT_PERIOD_MUTE: assert property (@(posedge clk) disable iff (rst)
    (period_q < PER_W'(MIN_PER)) |-> (level_out == '0)); // R8
  AST_SWEEP_MUTE: assert property (@(posedge clk) disable iff (rst) sweep_mute |=> (level_out == '0)); // R9
  AST_LEN_MUTE: assert property (@(posedge clk) disable iff (rst) len_zero |=> (level_out == '0)); // R10
  AST_LEVEL_IS_VOL: assert property (@(posedge clk) disable iff (rst)
    (level_out != '0) |-> (level_out == $past(vol_in))); // R11
endmodule

bind sq_voice_top sq_voice_chk #(.ADDR_W(ADDR_W), .VOL_W(VOL_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .vol_in(vol_in),
  .sweep_mute(sweep_mute), .len_zero(len_zero), .env_restart(env_restart),
  .level_out(level_out), .period_q(period_q), .pos_q(pos_q), .seq_step(seq_step)
);

// File: tb/tb_sq_voice_top.sv
module tb_sq_voice_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] vol_in;
  logic       sweep_mute, len_zero;
  logic       env_restart;
  logic [3:0] level_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sq_voice_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vol_in(vol_in), .sweep_mute(sweep_mute), .len_zero(len_zero),
    .env_restart(env_restart), .level_out(level_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_period(input int t);
    wr(2'd2, t[7:0]);
    wr(2'd3, {5'b0, t[10:8]});
  endtask

  task automatic settle();
    repeat (4200) @(negedge clk);
  endtask

  task automatic count_level(input int n, input int val, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (val < 0) begin
        if (level_out != 0) cnt++;
      end else if (int'(level_out) == val) cnt++;
    end
  endtask

  // waits for a rising (rise=1) or falling output edge, returns cycle count
  task automatic find_edge(input bit rise, output int c, output bit ok);
    bit prev;
    bit now;
    prev = (level_out != 0);
    ok = 1'b0;
    c = 0;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      now = (level_out != 0);
      if (rise ? (now && !prev) : (!now && prev)) begin
        c = cyc; ok = 1'b1;
        break;
      end
      prev = now;
    end
  endtask

  task automatic t_reset();
    chk("R1 level after reset", level_out, 0);
    chk("R1 env_restart after reset", env_restart, 0);
  endtask

  task automatic t_period();
    int c0, c1;
    bit ok0, ok1;
    vol_in = 4'd9;
    wr(2'd0, 8'h80);
    set_period(261);
    settle();
    find_edge(1'b1, c0, ok0);
    find_edge(1'b1, c1, ok1);
    chk("R2 edges found t=261", ok0 && ok1, 1);
    chk("R2 waveform clocks t=261", c1 - c0, 16 * 262);
    set_period(20);
    settle();
    find_edge(1'b1, c0, ok0);
    find_edge(1'b1, c1, ok1);
    chk("R2 waveform clocks t=20", c1 - c0, 16 * 21);
  endtask

  task automatic t_duty_highs();
    int ones[4] = '{1, 2, 4, 6};
    int h;
    set_period(30);
    settle();
    for (int d = 0; d < 4; d++) begin
      wr(2'd0, 8'(d << 6));
      count_level(16 * 31, -1, h);
      chk($sformatf("R3 high clocks duty %0d", d), h, ones[d] * 2 * 31);
    end
  endtask

  task automatic t_duty_switch();
    int c;
    bit ok;
    wr(2'd0, 8'h80);
    set_period(100);
    settle();
    find_edge(1'b1, c, ok);
    chk("R4 rising edge found", ok, 1);
    wr(2'd0, 8'h00);
    chk("R4 duty0 at pos4", level_out, 0);
    wr(2'd0, 8'hC0);
    chk("R4 duty3 at pos4", level_out, 9);
    wr(2'd0, 8'h40);
    chk("R4 duty1 at pos4", level_out, 0);
    wr(2'd0, 8'h80);
    chk("R4 duty2 back at pos4", level_out, 9);
  endtask

  task automatic t_restart();
    int guard = 0;
    wr(2'd0, 8'hC0);
    while (level_out != 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk("R5 reached low position", level_out, 0);
    wr(2'd3, 8'hF8);
    chk("R5 restart gives position 0 level", level_out, 9);
    chk("R6 env_restart raised", env_restart, 1);
    @(negedge clk);
    chk("R6 env_restart one clock", env_restart, 0);
    wr(2'd2, 8'd100);
    chk("R6 no pulse on low write", env_restart, 0);
    wr(2'd0, 8'hC0);
    chk("R6 no pulse on ctrl write", env_restart, 0);
  endtask

  task automatic t_divider();
    int c0, c1;
    bit ok0, ok1;
    wr(2'd0, 8'hC0);
    set_period(50);
    settle();
    find_edge(1'b0, c0, ok0);
    repeat (30) @(negedge clk);
    wr(2'd3, 8'h00);
    chk("R7 restart level", level_out, 9);
    find_edge(1'b0, c1, ok1);
    chk("R7 edges found", ok0 && ok1, 1);
    chk("R7 timing kept across restart", c1 - c0, 12 * 51);
  endtask

  task automatic t_minper();
    int h;
    wr(2'd0, 8'hC0);
    set_period(7);
    settle();
    count_level(400, -1, h);
    chk("R8 period 7 muted", h, 0);
    set_period(8);
    settle();
    count_level(144, -1, h);
    chk("R8 period 8 audible", h, 108);
  endtask

  task automatic t_mutes();
    int h;
    @(negedge clk) sweep_mute = 1'b1;
    count_level(144, -1, h);
    chk("R9 sweep mute", h, 0);
    @(negedge clk) begin sweep_mute = 1'b0; len_zero = 1'b1; end
    count_level(144, -1, h);
    chk("R10 length zero mute", h, 0);
    @(negedge clk) begin len_zero = 1'b0; vol_in = 4'd5; end
    count_level(144, 5, h);
    chk("R11 level equals vol 5", h, 108);
    @(negedge clk) vol_in = 4'd15;
    count_level(144, 15, h);
    chk("R11 level equals vol 15", h, 108);
    @(negedge clk) vol_in = 4'd0;
    count_level(144, -1, h);
    chk("R11 vol 0 silent", h, 0);
    @(negedge clk) vol_in = 4'd9;
  endtask

  task automatic t_ignored();
    int h;
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'hFF);
    wr(2'd3, 8'hF8);
    chk("R12 env pulse on padded high write", env_restart, 1);
    count_level(144, -1, h);
    chk("R12 ignored bits and index 1", h, 108);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    vol_in = 4'd9; sweep_mute = 1'b0; len_zero = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_period();
    t_duty_highs();
    t_duty_switch();
    t_restart();
    t_divider();
    t_minper();
    t_mutes();
    t_ignored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule